// File: doc/BRIEF.md
# PPS-Aligned Absolute Timekeeper

The block keeps absolute time as two counters: whole seconds and sub-second ticks. The ticks counter advances once per clock. When it reaches a programmable ticks-per-second limit it wraps to zero, and seconds advance by one on the same clock.

Software sets the time through a small register write port. It first writes a candidate seconds value, then a candidate ticks value. The ticks write arms the load. Immediate mode applies the armed values on the next clock. The default mode applies them at the first qualifying pulse-per-second edge and then disarms. The PPS pulse is taken from one of two pins, and either its rising or its falling transition can be chosen. The pin passes through a two-flop synchronizer before the edge is detected.

A read of seconds also captures ticks from the same cycle. A later read of ticks returns that captured value, so the pair of reads gives one consistent time.

Top module: `pps_timekeeper`

## Requirements
- R1: When reset is released, seconds, ticks, the read data and the captured ticks are 0, and no load is armed. Flags and the mode are 0, and ticks-per-second equals the parameter DEFAULT_TPS.
- R2: On each clock without a load, ticks increment by 1. When ticks+1 >= ticks-per-second, ticks become 0 and seconds increment by 1 on the same clock.
- R3: Write addresses: 0 holds the candidate seconds, 1 holds the candidate ticks and arms the load, 2 holds the flags (bits 1:0), 3 holds the mode (bit 0), and 4 holds ticks-per-second.
- R4: When mode bit 0 is 1, an armed load takes effect on the clock after the ticks write. The counters then show exactly the candidate values.
- R5: When mode bit 0 is 0, the candidate values are held and not applied until a qualifying PPS edge arrives. They take effect on the third rising clock edge after the pin changes: two synchronizer stages plus one edge stage.
- R6: Flags bit 0 selects the qualifying PPS transition: 0 for falling, 1 for rising. A transition in the other direction loads nothing.
- R7: Flags bit 1 selects the PPS pin: 0 for pps_a, 1 for pps_b. Edges on the pin that is not selected load nothing.
- R8: An armed load is applied exactly once and then disarms. Later PPS edges do not reload the counters.
- R9: A new candidate write before the qualifying edge replaces the earlier candidate values.
- R10: A read of address 0 returns seconds on rd_data one clock later and captures ticks from that same clock. A read of address 1 returns the captured ticks one clock later. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_a | input | 1 | First PPS pin (asynchronous) |
| pps_b | input | 1 | Alternate PPS pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | TIME_W | Register write data |
| rd_en | input | 1 | Readback strobe |
| rd_addr | input | 3 | Readback address |
| rd_data | output | TIME_W | Readback data, registered |

## Verification
The counter is loaded directly under a small ticks-per-second value. This separates an exact load (R4) from the wrap into seconds (R2), and the seconds/ticks read pair shows that the captured ticks do not follow the live counter. In PPS mode the pins are pulsed with the wrong polarity, then on the pin that is not selected, then correctly. Only the last pulse may load, and it must land on the exact cycle that the synchronizer depth predicts. A second correct pulse with no new write, and a double write before the pulse, tell one-shot disarming and value replacement apart from reloading or keeping stale values.

// File: rtl/tk_pkg.sv
// Package: shared register addresses for the timekeeper.
// Assumes a 3-bit address space for both write and read ports.
package tk_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_SECS  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TICKS = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TPS   = 3'd4;
    localparam int FLAG_EDGE = 0;
    localparam int FLAG_SRC  = 1;
endpackage

// File: rtl/tk_pps_edge.sv
// Module: selects one PPS pin, synchronizes it with two flops and flags
// the chosen transition as a one-cycle pulse.
// Assumes the pins are asynchronous and much slower than clk.
module tk_pps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    input  logic pin_b,
    input  logic use_b,
    input  logic rising,
    output logic edge_o
);
    logic raw;
    logic s1, s2, s3;

    // Pin select ahead of the synchronizer.
    always_comb raw = use_b ? pin_b : pin_a;

    // Two-flop synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Transition detect of the chosen polarity.
    always_comb edge_o = rising ? (s2 & ~s3) : (~s2 & s3);
endmodule

// File: rtl/tk_regs.sv
// Module: register file holding the candidate time, flags, mode and
// ticks-per-second. Arms the load on a ticks write and fires it either
// at once or on a PPS edge.
// Assumes single-cycle write strobes.
module tk_regs #(
    parameter int TIME_W      = 32,
    parameter int DEFAULT_TPS = 100_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tk_pkg::ADDR_W-1:0] wr_addr,
    input  logic [TIME_W-1:0]         wr_data,
    input  logic                      pps_edge,
    output logic [TIME_W-1:0]         cand_secs,
    output logic [TIME_W-1:0]         cand_ticks,
    output logic [TIME_W-1:0]         tps,
    output logic                      use_b,
    output logic                      rising,
    output logic                      fire
);
    import tk_pkg::*;

    logic armed;
    logic immediate;
    logic ticks_wr;

    // Decode of the arming write.
    always_comb ticks_wr = wr_en && (wr_addr == A_TICKS);

    // Load fires when armed and either immediate or on the PPS edge.
    always_comb fire = armed && (immediate || pps_edge);

    // Configuration and candidate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_secs  <= '0;
            cand_ticks <= '0;
            tps        <= TIME_W'(DEFAULT_TPS);
            use_b      <= 1'b0;
            rising     <= 1'b0;
            immediate  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SECS:  cand_secs  <= wr_data;
                A_TICKS: cand_ticks <= wr_data;
                A_FLAGS: begin
                    rising <= wr_data[FLAG_EDGE];
                    use_b  <= wr_data[FLAG_SRC];
                end
                A_MODE:  immediate  <= wr_data[0];
                A_TPS:   tps        <= wr_data;
                default: ;
            endcase
        end
    end

    // Arm flag: set by a ticks write, cleared once the load fires.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (ticks_wr) armed <= 1'b1;
        else if (fire)     armed <= 1'b0;
    end

    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_wr |=> armed);
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ticks_wr) |=> !armed);
endmodule

// File: rtl/tk_counter.sv
// Module: seconds and ticks counters with programmable wrap and a
// parallel load.
// Assumes a load takes priority over counting in the same cycle.
module tk_counter #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] ld_secs,
    input  logic [TIME_W-1:0] ld_ticks,
    input  logic [TIME_W-1:0] tps,
    output logic [TIME_W-1:0] secs,
    output logic [TIME_W-1:0] ticks
);
    localparam int W1 = TIME_W + 1;

    logic wrap;

    // Wrap when the next tick would reach the per-second count.
    always_comb wrap = ({1'b0, ticks} + W1'(1)) >= {1'b0, tps};

    // Counter update: load, wrap into seconds, or plain increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs  <= '0;
            ticks <= '0;
        end else if (load) begin
            secs  <= ld_secs;
            ticks <= ld_ticks;
        end else if (wrap) begin
            secs  <= secs + 1'b1;
            ticks <= '0;
        end else begin
            ticks <= ticks + 1'b1;
        end
    end

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && wrap) |=> (ticks == '0) && (secs == $past(secs) + 1'b1));
    p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !wrap) |=> (ticks == $past(ticks) + 1'b1) && $stable(secs));
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (secs == $past(ld_secs)) && (ticks == $past(ld_ticks)));
endmodule

// File: rtl/tk_readback.sv
// Module: registered readback with a ticks capture taken on every
// seconds read.
// Assumes one-cycle read latency is acceptable to the reader.
module tk_readback #(
    parameter int TIME_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [tk_pkg::ADDR_W-1:0] rd_addr,
    input  logic [TIME_W-1:0]         secs,
    input  logic [TIME_W-1:0]         ticks,
    output logic [TIME_W-1:0]         rd_data
);
    import tk_pkg::*;

    logic [TIME_W-1:0] snap;

    // Read mux and ticks capture on a seconds read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            snap    <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                A_SECS: begin
                    rd_data <= secs;
                    snap    <= ticks;
                end
                A_TICKS: rd_data <= snap;
                default: rd_data <= '0;
            endcase
        end
    end

    p_snap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_SECS) |=> (snap == $past(ticks)));
endmodule

// File: rtl/pps_timekeeper.sv
// Module: top of the PPS-aligned timekeeper. Ties the pin selector,
// register file, counters and readback together.
// Assumes all register traffic is synchronous to clk.
module pps_timekeeper #(
    parameter int TIME_W      = 32,
    parameter int DEFAULT_TPS = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_a,
    input  logic              pps_b,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [TIME_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [TIME_W-1:0] rd_data
);
    logic              pps_edge, use_b, rising, fire;
    logic [TIME_W-1:0] cand_secs, cand_ticks, tps, secs, ticks;

    tk_pps_edge u_edge (
        .clk(clk), .rst_n(rst_n), .pin_a(pps_a), .pin_b(pps_b),
        .use_b(use_b), .rising(rising), .edge_o(pps_edge)
    );

    tk_regs #(.TIME_W(TIME_W), .DEFAULT_TPS(DEFAULT_TPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pps_edge(pps_edge), .cand_secs(cand_secs),
        .cand_ticks(cand_ticks), .tps(tps), .use_b(use_b),
        .rising(rising), .fire(fire)
    );

    tk_counter #(.TIME_W(TIME_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(fire), .ld_secs(cand_secs),
        .ld_ticks(cand_ticks), .tps(tps), .secs(secs), .ticks(ticks)
    );

    tk_readback #(.TIME_W(TIME_W)) u_rb (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .secs(secs), .ticks(ticks), .rd_data(rd_data)
    );
endmodule

// File: tb/pps_timekeeper_tb.sv
module pps_timekeeper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_a = 1'b0, pps_b = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    pps_timekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .pps_a(pps_a), .pps_b(pps_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_lt(input string tag, input logic [31:0] act, input logic [31:0] lim);
        n_chk++;
        if (!(act < lim)) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected below %0d", tag, act, lim);
        end
    endtask

    task automatic check_gt(input string tag, input logic [31:0] act, input logic [31:0] lim);
        n_chk++;
        if (!(act > lim)) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected above %0d", tag, act, lim);
        end
    endtask

    // Starts and ends on a negedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); @(negedge clk);
        v = rd_data; rd_en = 1'b0;
    endtask

    task automatic rd_pair(input string tag, input logic [31:0] es, input logic [31:0] et);
        logic [31:0] v;
        rd(3'd0, v); check({tag, " secs"}, v, es);
        @(posedge clk); @(negedge clk);   // live ticks move on, capture must not
        rd(3'd1, v); check({tag, " ticks"}, v, et);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); end
        @(negedge clk);
    endtask

    // Pin change at a negedge; the load lands on the third posedge after it.
    task automatic pin(input bit use_b, input logic v);
        if (use_b) pps_b = v; else pps_a = v;
    endtask

    task automatic t_reset;   // R1
        logic [31:0] v;
        check("R1 rd_data after reset", rd_data, 32'd0);
        rd(3'd0, v); check("R1 secs after reset", v, 32'd0);
        rd(3'd1, v); check("R1 ticks capture after reset", v, 32'd0);
        rd(3'd5, v); check("R10 unmapped read", v, 32'd0);
    endtask

    task automatic t_immediate;   // R3 R4
        wr(3'd4, 32'd10);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd7);
        wr(3'd1, 32'd2);
        wait_cyc(1);
        rd_pair("R4 immediate load", 32'd7, 32'd2);
    endtask

    task automatic t_wrap;   // R2
        wr(3'd0, 32'd5);
        wr(3'd1, 32'd8);
        wait_cyc(1);
        wait_cyc(2);
        rd_pair("R2 wrap into seconds", 32'd6, 32'd0);
    endtask

    task automatic t_pps_fall;   // R5 R6 R8
        logic [31:0] v;
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd0);
        wait_cyc(6);
        rd(3'd0, v); check_lt("R5 held without edge", v, 32'd100);
        pin(0, 1'b1); wait_cyc(6);
        rd(3'd0, v); check_lt("R6 rising ignored in falling mode", v, 32'd100);
        pin(0, 1'b0); wait_cyc(3);
        rd_pair("R5 falling edge load", 32'd100, 32'd0);
        pin(0, 1'b1); wait_cyc(5);
        pin(0, 1'b0); wait_cyc(3);
        rd(3'd0, v); check_gt("R8 no reload on second edge", v, 32'd100);
    endtask

    task automatic t_pps_rise_b;   // R6 R7
        logic [31:0] v;
        wr(3'd2, 32'd3);
        wr(3'd0, 32'd200);
        wr(3'd1, 32'd3);
        pin(0, 1'b1); wait_cyc(5);
        pin(0, 1'b0); wait_cyc(5);
        rd(3'd0, v); check_lt("R7 unselected pin ignored", v, 32'd200);
        pin(1, 1'b1); wait_cyc(3);
        rd_pair("R6 R7 rising edge on pps_b", 32'd200, 32'd3);
        pin(1, 1'b0); wait_cyc(2);
    endtask

    task automatic t_replace;   // R9
        logic [31:0] v;
        wr(3'd0, 32'd300);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd400);
        wr(3'd1, 32'd2);
        wait_cyc(4);
        rd(3'd0, v); check_lt("R9 held before edge", v, 32'd300);
        pin(1, 1'b1); wait_cyc(3);
        rd_pair("R9 latest write applied", 32'd400, 32'd2);
        pin(1, 1'b0); wait_cyc(2);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_immediate();
        t_wrap();
        t_pps_fall();
        t_pps_rise_b();
        t_replace();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule